// File: doc/BRIEF.md
# Infrared Run-Length Encoder

This block turns the output of an infrared receiver into a byte stream of run-length codes. The raw receiver line is passed through a two-flop synchronizer and an optional polarity inversion. It is then sampled once per sample tick, which is the module clock divided by a parameter (64 by default). An 8 MHz clock therefore gives an 8 µs sample period. Every stretch of constant level on the sampled line becomes one byte. The upper bit of the byte carries the level and the lower seven bits carry the stretch length in ticks, minus one.

Two programmable thresholds shape the stream. The noise threshold stops short glitches from splitting a run. The idle threshold closes a packet once the line has rested at the space level long enough, and marks the close with a single-cycle strobe. Codes leave through a valid/ready handshake. The code being offered is held until it is taken. If a further code arrives while one is still pending, it is dropped and a sticky overflow flag is set. Buffering, the register interface and protocol decoding live elsewhere.

Top module: `irle_encoder`

## Requirements
- R1: The line is taken through two synchronizer flops and sampled only on the sample tick, one tick every DIV clocks after both enables rise. A code that closes on the k-th sample appears on `code_valid` at the k*DIV-th rising edge after enabling.
- R2: Each code packs the level into bit 7 (1 = pulse, the active level; 0 = space) and the run length in ticks minus one into bits 6:0.
- R3: With `invert` set, the synchronized line is complemented before sampling, so a low raw level counts as a pulse.
- R4: A change of level that lasts no more than `noise_thr` samples is ignored, and its samples are added to the surrounding run. A level that holds for `noise_thr`+1 samples is accepted, and its run starts with that many samples already counted.
- R5: A run that reaches 128 samples produces a saturated code (bits 6:0 = 127), and counting continues as a new run of the same level. A run of exactly 128 samples yields only the saturated code.
- R6: Once the accepted level is space and `idle_thr` consecutive space samples have been seen (counting glitch-free samples only, with `idle_thr` greater than `noise_thr`+1), `pkt_end` pulses for one cycle. No code is produced for that space.
- R7: While idle (after a packet end, after reset or after enabling), space samples produce nothing. The next code stream begins with the first accepted pulse.
- R8: The block runs only while `glb_en` and `rx_en` are both high. Clearing either returns it to the idle state, discards any partial run and clears `code_valid` and `code_ovf`.
- R9: While `code_valid` is high and `code_ready` is low, `code_valid` stays high and `code_data` stays stable.
- R10: A code produced while another is pending and not being taken is dropped, and `code_ovf` is set and stays set until reset or disable.
- R11: In reset, `code_valid`, `pkt_end` and `code_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| rx_raw | input | 1 | Asynchronous receiver line |
| invert | input | 1 | Complement the line before sampling |
| noise_thr | input | NOISE_W (6) | Longest ignored glitch, in samples |
| idle_thr | input | IDLE_W (8) | Space samples that end a packet |
| code_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| code_valid | output | 1 | Code available |
| code_ready | input | 1 | Downstream accepts the code |
| pkt_end | output | 1 | One-cycle packet-end strobe |
| code_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench changes the line level one clock after each sample window opens. Every level is therefore settled through the two synchronizer flops well before the tick edge that samples it. A code, or a packet-end strobe, is registered on the very tick edge that closes its run. The tick for sample k falls on rising edge k*DIV after enabling, so the result is visible at the following falling edge. One directed check counts those falling edges exactly. The other checks collect codes at every falling edge and compare them, in order, once a sequence has fully settled. The backpressure and disable checks sample the held outputs one falling edge after the edge that should change them.

// File: rtl/irle_pkg.sv
package irle_pkg;
  localparam int CODE_W  = 8;
  localparam int LEN_W   = CODE_W - 1;
  localparam int MAX_RUN = 1 << LEN_W;
  localparam logic LVL_SPACE = 1'b0;
  localparam logic LVL_PULSE = 1'b1;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/irle_tick_gen.sv
module irle_tick_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/irle_sampler.sv
module irle_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_raw,
  input  logic invert,
  output logic level
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], rx_raw};
  end

  assign level = sh[STAGES-1] ^ invert;
endmodule

// File: rtl/irle_runlen.sv
module irle_runlen
  import irle_pkg::*;
#(
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               tick,
  input  logic               level,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  output logic               emit,
  output code_t              emit_code,
  output logic               end_pkt
);
  localparam int CNT_W = ((LEN_W > NOISE_W) ? LEN_W : NOISE_W) + 2;
  localparam logic [CNT_W-1:0] RUN_LIM = CNT_W'(MAX_RUN);

  logic               cur_lvl,  n_lvl;
  logic [CNT_W-1:0]   run_cnt,  n_run;
  logic [NOISE_W-1:0] cand_cnt, n_cand;
  logic [IDLE_W-1:0]  idle_cnt, n_idle_cnt;
  logic               idle_q,   n_idle;
  logic [CNT_W-1:0]   sum;

  always_comb begin
    n_lvl      = cur_lvl;
    n_run      = run_cnt;
    n_cand     = cand_cnt;
    n_idle_cnt = idle_cnt;
    n_idle     = idle_q;
    sum        = run_cnt + CNT_W'(cand_cnt) + CNT_W'(1);
    emit       = 1'b0;
    end_pkt    = 1'b0;
    emit_code  = {cur_lvl, LEN_W'(run_cnt - CNT_W'(1))};
    if (tick) begin
      // consecutive space samples, restarted by any active sample
      if (level)                n_idle_cnt = '0;
      else if (idle_cnt != '1)  n_idle_cnt = idle_cnt + 1'b1;

      if (level != cur_lvl) begin
        if (cand_cnt >= noise_thr) begin
          // new level accepted: close the old run
          if (!idle_q && run_cnt != '0) emit = 1'b1;
          n_lvl  = level;
          n_run  = CNT_W'(cand_cnt) + CNT_W'(1);
          n_cand = '0;
          n_idle = 1'b0;
        end else begin
          n_cand = cand_cnt + 1'b1;
        end
      end else begin
        n_cand = '0;
        if (idle_q) begin
          n_run = '0;
        end else begin
          // glitch samples fold back into the current run
          if (sum >= RUN_LIM) begin
            emit      = 1'b1;
            emit_code = {cur_lvl, {LEN_W{1'b1}}};
            n_run     = sum - RUN_LIM;
          end else begin
            n_run = sum;
          end
          if (cur_lvl == LVL_SPACE && n_idle_cnt >= idle_thr) begin
            end_pkt = 1'b1;
            n_idle  = 1'b1;
            n_run   = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cur_lvl  <= LVL_SPACE;
      run_cnt  <= '0;
      cand_cnt <= '0;
      idle_cnt <= '0;
      idle_q   <= 1'b1;
    end else begin
      cur_lvl  <= n_lvl;
      run_cnt  <= n_run;
      cand_cnt <= n_cand;
      idle_cnt <= n_idle_cnt;
      idle_q   <= n_idle;
    end
  end
endmodule

// File: rtl/irle_outreg.sv
module irle_outreg
  import irle_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  logic  emit,
  input  code_t emit_code,
  input  logic  end_pkt,
  input  logic  ready,
  output code_t data,
  output logic  valid,
  output logic  pkt_end,
  output logic  ovf
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      data    <= '0;
      valid   <= 1'b0;
      pkt_end <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      pkt_end <= end_pkt;
      if (emit) begin
        if (valid && !ready) begin
          ovf <= 1'b1;
        end else begin
          data  <= emit_code;
          valid <= 1'b1;
        end
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irle_encoder.sv
module irle_encoder
  import irle_pkg::*;
#(
  parameter int DIV     = 64,
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic               rx_en,
  input  logic               rx_raw,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  output logic [CODE_W-1:0]  code_data,
  output logic               code_valid,
  input  logic               code_ready,
  output logic               pkt_end,
  output logic               code_ovf
);
  logic  run, tick, level, emit, end_pkt;
  code_t emit_code;

  assign run = glb_en && rx_en;

  irle_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  irle_sampler #(.STAGES(SYNC_N)) u_samp (
    .clk(clk), .rst(rst), .rx_raw(rx_raw), .invert(invert), .level(level)
  );

  irle_runlen #(.NOISE_W(NOISE_W), .IDLE_W(IDLE_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .level(level),
    .noise_thr(noise_thr), .idle_thr(idle_thr),
    .emit(emit), .emit_code(emit_code), .end_pkt(end_pkt)
  );

  irle_outreg u_out (
    .clk(clk), .rst(rst), .run(run), .emit(emit), .emit_code(emit_code),
    .end_pkt(end_pkt), .ready(code_ready), .data(code_data),
    .valid(code_valid), .pkt_end(pkt_end), .ovf(code_ovf)
  );
endmodule

// File: rtl/irle_encoder_chk.sv
module irle_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       glb_en,
  input logic       rx_en,
  input logic [7:0] code_data,
  input logic       code_valid,
  input logic       code_ready,
  input logic       pkt_end,
  input logic       code_ovf
);
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (code_valid && !code_ready && glb_en && rx_en) |=> (code_valid && $stable(code_data)));

  p_ovf_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(code_ovf) |-> $past(code_valid && !code_ready));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (code_ovf && glb_en && rx_en) |=> code_ovf);

  p_end_single_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> !pkt_end);

  p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !(glb_en && rx_en) |=> (!code_valid && !pkt_end && !code_ovf));
endmodule

bind irle_encoder irle_encoder_chk u_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .rx_en(rx_en),
  .code_data(code_data), .code_valid(code_valid), .code_ready(code_ready),
  .pkt_end(pkt_end), .code_ovf(code_ovf)
);

// File: tb/irle_encoder_bench.sv
`timescale 1ns/1ps
module irle_encoder_bench;
  localparam int DIV = 64;
  localparam int END_MARK = 256;

  typedef struct packed {
    logic       lvl;
    logic [7:0] n;
  } seg_t;

  // noise 1, idle 20, no inversion
  localparam seg_t MAIN_SEGS [11] = '{
    '{1'b0, 8'd5},  '{1'b1, 8'd10}, '{1'b0, 8'd4},  '{1'b1, 8'd1},
    '{1'b0, 8'd3},  '{1'b1, 8'd6},  '{1'b0, 8'd25}, '{1'b1, 8'd130},
    '{1'b0, 8'd2},  '{1'b1, 8'd2},  '{1'b0, 8'd30}
  };
  localparam int MAIN_EXP [9] = '{'h89, 'h07, 'h85, END_MARK, 'hFF, 'h81, 'h01, 'h81, END_MARK};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       glb_en = 1'b0, rx_en = 1'b0, rx_raw = 1'b0, invert = 1'b0;
  logic [5:0] noise_thr = 6'd1;
  logic [7:0] idle_thr = 8'd20;
  logic [7:0] code_data;
  logic       code_valid, code_ready = 1'b1, pkt_end, code_ovf;

  int n_checks = 0;
  int n_fail = 0;
  int got[$];
  int exp_q[$];

  always #10 clk = ~clk;

  irle_encoder #(.DIV(DIV)) u_irle_encoder (
    .clk(clk), .rst(rst), .glb_en(glb_en), .rx_en(rx_en), .rx_raw(rx_raw),
    .invert(invert), .noise_thr(noise_thr), .idle_thr(idle_thr),
    .code_data(code_data), .code_valid(code_valid), .code_ready(code_ready),
    .pkt_end(pkt_end), .code_ovf(code_ovf)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (code_valid && code_ready) got.push_back(int'(code_data));
      if (pkt_end) got.push_back(END_MARK);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic restart(input logic inv, input int nthr, input int ithr, input logic first_raw);
    @(negedge clk);
    glb_en = 1'b0; rx_en = 1'b0;
    invert = inv; noise_thr = 6'(nthr); idle_thr = 8'(ithr);
    rx_raw = first_raw; code_ready = 1'b1;
    repeat (4) @(negedge clk);
    got.delete();
    glb_en = 1'b1; rx_en = 1'b1;
  endtask

  task automatic drive(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      rx_raw = lvl;
      repeat (DIV) @(negedge clk);
    end
  endtask

  task automatic compare(input string tag);
    repeat (4) @(negedge clk);
    check(got.size() == exp_q.size(), {tag, " code count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(got[i] == exp_q[i], $sformatf("%s item %0d", tag, i), got[i], exp_q[i]);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cyc;
    // R11: reset state with enables high
    glb_en = 1'b1; rx_en = 1'b1; rx_raw = 1'b1;
    repeat (5) @(negedge clk);
    check(code_valid == 1'b0, "R11 valid in reset", code_valid, 0);
    check(pkt_end == 1'b0, "R11 pkt_end in reset", pkt_end, 0);
    check(code_ovf == 1'b0, "R11 ovf in reset", code_ovf, 0);
    rst = 1'b0;

    // Table walk: R2 R4 R5 R6 R7
    restart(1'b0, 1, 20, 1'b0);
    foreach (MAIN_SEGS[i]) drive(MAIN_SEGS[i].lvl, int'(MAIN_SEGS[i].n));
    foreach (MAIN_EXP[i]) exp_q.push_back(MAIN_EXP[i]);
    compare("R2/R4/R5/R6/R7 table");

    // R1: code closing on sample 4 appears at edge 4*DIV
    restart(1'b0, 0, 255, 1'b1);
    repeat (3 * DIV) @(negedge clk);
    rx_raw = 1'b0;
    cyc = 3 * DIV;
    while (!code_valid && cyc < 10 * DIV) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 4 * DIV, "R1 code timing", cyc, 4 * DIV);
    check(code_data == 8'h82, "R1 code value", code_data, 'h82);

    // R3: inverted line, noise 0, idle 4
    restart(1'b1, 0, 4, 1'b1);
    drive(1'b1, 3); drive(1'b0, 5); drive(1'b1, 6);
    exp_q.push_back('h84); exp_q.push_back(END_MARK);
    compare("R3 invert");

    // R5: exactly 128 samples
    restart(1'b0, 0, 4, 1'b1);
    drive(1'b1, 128); drive(1'b0, 6);
    exp_q.push_back('hFF); exp_q.push_back(END_MARK);
    compare("R5 exact 128");

    // R4: noise threshold 3
    restart(1'b0, 3, 10, 1'b1);
    drive(1'b1, 6); drive(1'b0, 3); drive(1'b1, 2); drive(1'b0, 12);
    exp_q.push_back('h8A); exp_q.push_back(END_MARK);
    compare("R4 noise 3");

    // R9 / R10: backpressure and overflow
    restart(1'b0, 0, 200, 1'b1);
    code_ready = 1'b0;
    drive(1'b1, 2); drive(1'b0, 2); drive(1'b1, 2);
    check(code_valid == 1'b1, "R9 valid held", code_valid, 1);
    check(code_data == 8'h81, "R9 data held", code_data, 'h81);
    check(code_ovf == 1'b1, "R10 overflow set", code_ovf, 1);
    code_ready = 1'b1;
    @(negedge clk);
    check(code_valid == 1'b0, "R9 taken", code_valid, 0);
    check(code_ovf == 1'b1, "R10 overflow sticky", code_ovf, 1);
    rx_en = 1'b0;
    @(negedge clk);
    check(code_ovf == 1'b0, "R8 overflow cleared by disable", code_ovf, 0);

    // R8: disable mid-run discards the partial pulse
    restart(1'b0, 1, 20, 1'b1);
    drive(1'b1, 5);
    restart(1'b0, 1, 20, 1'b0);
    drive(1'b0, 25); drive(1'b1, 3); drive(1'b0, 22);
    exp_q.push_back('h82); exp_q.push_back(END_MARK);
    compare("R8 disable");

    summary();
  end
endmodule